// File: doc/BRIEF.md
# Nonce Search and Result Controller

This block sits between a host and a bank of parallel hashing cores. The host loads a job: the work data, a first nonce, a last nonce and a 256-bit target. A hardware counter then walks the nonce range and fills a small candidate queue. The hashing cores take candidates from that queue through a per-core request/grant port. A round-robin arbiter makes sure that each candidate goes to exactly one core.

Each core returns its nonce and 256-bit digest through a per-core result port. The block compares the digest against the target. Only winning nonces are written into a result FIFO that the host reads, so host traffic scales with the number of hits and not with the hash rate. A full FIFO raises a sticky overflow flag. A flush input aborts the job, empties the candidate queue and drops any hit that is still in flight.

Top module: `nonce_search_ctrl`

## Requirements
- R1: A cycle with `load_i` high latches `work_i`, `first_i`, `last_i` and `target_i`. From the next cycle on, `work_o` shows the latched work data.
- R2: After a load, the generator produces every nonce from `first_i` up to `last_i` inclusive. The nonces are produced in increasing order, each exactly once, and the cores receive them in that order.
- R3: Once the last nonce has entered the queue, `done_o` goes high and stays high until the next load or flush. No further nonces are issued. A new load clears `done_o` and restarts the count.
- R4: At most one bit of `core_gnt_o` is high in a cycle. A grant goes only to a core whose request is high, and only while a candidate is queued. `cand_o` carries the granted nonce in the grant cycle.
- R5: Candidate grants rotate round-robin: the search starts at the core after the last one granted. After reset, core 0 has the highest priority.
- R6: A result is a hit when its digest, read as an unsigned 256-bit number, is less than or equal to the target. A hit accepted in one cycle is readable at the FIFO head after the second following clock edge. A miss never enters the FIFO.
- R7: `res_ack_o[i]` is high in the cycle that core i's result is taken. Misses are acknowledged at once. Hits are taken one per cycle in round-robin order (core 0 first after reset), so a core holds its result until it is acknowledged.
- R8: The result FIFO returns hits in the order they were taken. `fifo_valid_o` shows that `fifo_nonce_o` is valid, and `fifo_rd_i` removes the head entry.
- R9: A hit that reaches a full FIFO is discarded and sets `overflow_o`. The flag stays set until the next load or reset.
- R10: A cycle with `flush_i` high does the following:
  - stops the generator and clears `done_o`;
  - empties the candidate queue, so no grant follows;
  - drops the hit waiting to be written;
  - acknowledges and drops any result presented in that cycle.

  Entries already in the FIFO remain.
- R11: After reset: no grant, `done_o` low, `overflow_o` low, FIFO empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load a new job and start the search |
| flush_i | input | 1 | Abort the job and clear in-flight state |
| work_i | input | WORK_W | Work data of the job |
| first_i | input | NONCE_W | First nonce of the range |
| last_i | input | NONCE_W | Last nonce of the range (inclusive) |
| target_i | input | HASH_W | Acceptance threshold for digests |
| work_o | output | WORK_W | Latched work data broadcast to the cores |
| core_req_i | input | CORES | Per-core candidate request |
| core_gnt_o | output | CORES | Per-core candidate grant |
| cand_o | output | NONCE_W | Nonce handed to the granted core |
| res_valid_i | input | CORES | Per-core result valid |
| res_nonce_i | input | CORES*NONCE_W | Per-core result nonces, core i at bits [i*NONCE_W +: NONCE_W] |
| res_hash_i | input | CORES*HASH_W | Per-core digests, core i at bits [i*HASH_W +: HASH_W] |
| res_ack_o | output | CORES | Per-core result taken |
| fifo_rd_i | input | 1 | Pop the head of the result FIFO |
| fifo_valid_o | output | 1 | Result FIFO not empty |
| fifo_nonce_o | output | NONCE_W | Winning nonce at the FIFO head |
| done_o | output | 1 | Whole range issued |
| overflow_o | output | 1 | Sticky: a hit was lost to a full FIFO |

## Verification
The hardest state to reach from the ports is a hit that has been acknowledged but not yet written, at the moment a flush arrives. It exists for a single cycle. The bench creates it by presenting a hit, waiting exactly one edge, and asserting flush in the next cycle. It then checks that the FIFO still holds only the earlier winner. Two cores hitting in the same cycle, and a FIFO filled to capacity by back-to-back hits with no reads, are also driven on purpose. These show the one-per-cycle acceptance order and the overflow flag.

// File: rtl/nsc_pkg.sv
package nsc_pkg;
    localparam int NONCE_W_DEF  = 32;
    localparam int HASH_W_DEF   = 256;
    localparam int WORK_W_DEF   = 96;
    localparam int CORES_DEF    = 4;
    localparam int CQ_DEPTH_DEF = 4;
    localparam int RF_DEPTH_DEF = 4;

    typedef enum logic [1:0] {
        GEN_IDLE,
        GEN_RUN,
        GEN_DONE
    } gen_state_e;
endpackage

// File: rtl/nsc_fifo.sv
module nsc_fifo #(
    parameter int W = 32,
    parameter int D = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (D > 1) ? $clog2(D) : 1;

    logic [W-1:0]  mem [D];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == (AW+1)'(D));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push && !clr && !rst) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(D-1)) ? '0 : wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(D-1)) ? '0 : rd_ptr + AW'(1);
            count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end
endmodule

// File: rtl/nsc_rr_arb.sv
module nsc_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] last_q, gidx;
    logic          found;
    int            idx;

    always_comb begin
        gnt   = '0;
        gidx  = last_q;
        found = 1'b0;
        idx   = 0;
        for (int k = 1; k <= N; k++) begin
            idx = (int'(last_q) + k) % N;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                gidx     = IW'(idx);
                found    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        last_q <= IW'(N-1);
        else if (found) last_q <= gidx;
    end
endmodule

// File: rtl/nsc_gen.sv
module nsc_gen
    import nsc_pkg::*;
#(
    parameter int NONCE_W = NONCE_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               flush,
    input  logic [NONCE_W-1:0] first,
    input  logic [NONCE_W-1:0] last,
    input  logic               q_full,
    output logic               push,
    output logic [NONCE_W-1:0] nonce,
    output logic               done
);
    gen_state_e         state;
    logic [NONCE_W-1:0] cur, stop;

    assign push  = (state == GEN_RUN) && !q_full && !flush && !load;
    assign nonce = cur;
    assign done  = (state == GEN_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= GEN_IDLE;
            cur   <= '0;
            stop  <= '0;
        end else if (flush) begin
            state <= GEN_IDLE;
        end else if (load) begin
            state <= GEN_RUN;
            cur   <= first;
            stop  <= last;
        end else if (push) begin
            if (cur == stop) state <= GEN_DONE;
            else             cur   <= cur + NONCE_W'(1);
        end
    end
endmodule

// File: rtl/nonce_search_ctrl.sv
module nonce_search_ctrl
    import nsc_pkg::*;
#(
    parameter int NONCE_W  = NONCE_W_DEF,
    parameter int HASH_W   = HASH_W_DEF,
    parameter int WORK_W   = WORK_W_DEF,
    parameter int CORES    = CORES_DEF,
    parameter int CQ_DEPTH = CQ_DEPTH_DEF,
    parameter int RF_DEPTH = RF_DEPTH_DEF
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load_i,
    input  logic                      flush_i,
    input  logic [WORK_W-1:0]         work_i,
    input  logic [NONCE_W-1:0]        first_i,
    input  logic [NONCE_W-1:0]        last_i,
    input  logic [HASH_W-1:0]         target_i,
    output logic [WORK_W-1:0]         work_o,
    input  logic [CORES-1:0]          core_req_i,
    output logic [CORES-1:0]          core_gnt_o,
    output logic [NONCE_W-1:0]        cand_o,
    input  logic [CORES-1:0]          res_valid_i,
    input  logic [CORES*NONCE_W-1:0]  res_nonce_i,
    input  logic [CORES*HASH_W-1:0]   res_hash_i,
    output logic [CORES-1:0]          res_ack_o,
    input  logic                      fifo_rd_i,
    output logic                      fifo_valid_o,
    output logic [NONCE_W-1:0]        fifo_nonce_o,
    output logic                      done_o,
    output logic                      overflow_o
);
    logic [WORK_W-1:0]  work_q;
    logic [HASH_W-1:0]  target_q;

    logic               gen_push;
    logic [NONCE_W-1:0] gen_nonce;
    logic               cq_empty, cq_full;
    logic [CORES-1:0]   cand_req;

    logic [CORES-1:0]   hit, hit_gnt;
    logic [NONCE_W-1:0] hit_nonce;
    logic               stage_vld;
    logic [NONCE_W-1:0] stage_nonce;
    logic               rf_empty, rf_full;

    // job registers
    always_ff @(posedge clk) begin
        if (rst) begin
            work_q   <= '0;
            target_q <= '0;
        end else if (load_i) begin
            work_q   <= work_i;
            target_q <= target_i;
        end
    end
    assign work_o = work_q;

    // candidate side
    nsc_gen #(.NONCE_W(NONCE_W)) u_gen (
        .clk(clk), .rst(rst), .load(load_i), .flush(flush_i),
        .first(first_i), .last(last_i), .q_full(cq_full),
        .push(gen_push), .nonce(gen_nonce), .done(done_o)
    );

    nsc_fifo #(.W(NONCE_W), .D(CQ_DEPTH)) u_cand_q (
        .clk(clk), .rst(rst), .clr(flush_i || load_i),
        .push(gen_push), .din(gen_nonce),
        .pop(|core_gnt_o), .dout(cand_o),
        .empty(cq_empty), .full(cq_full)
    );

    assign cand_req = core_req_i & {CORES{!cq_empty && !flush_i && !load_i}};

    nsc_rr_arb #(.N(CORES)) u_cand_arb (
        .clk(clk), .rst(rst), .req(cand_req), .gnt(core_gnt_o)
    );

    // result side
    for (genvar g = 0; g < CORES; g++) begin : g_hit
        assign hit[g] = res_valid_i[g] &&
                        (res_hash_i[g*HASH_W +: HASH_W] <= target_q);
    end

    nsc_rr_arb #(.N(CORES)) u_hit_arb (
        .clk(clk), .rst(rst), .req(hit & {CORES{!flush_i}}), .gnt(hit_gnt)
    );

    assign res_ack_o = flush_i ? res_valid_i : ((res_valid_i & ~hit) | hit_gnt);

    always_comb begin
        hit_nonce = '0;
        for (int i = 0; i < CORES; i++)
            if (hit_gnt[i]) hit_nonce = res_nonce_i[i*NONCE_W +: NONCE_W];
    end

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            stage_vld   <= 1'b0;
            stage_nonce <= '0;
        end else begin
            stage_vld   <= |hit_gnt;
            stage_nonce <= hit_nonce;
        end
    end

    nsc_fifo #(.W(NONCE_W), .D(RF_DEPTH)) u_res_q (
        .clk(clk), .rst(rst), .clr(1'b0),
        .push(stage_vld && !flush_i), .din(stage_nonce),
        .pop(fifo_rd_i), .dout(fifo_nonce_o),
        .empty(rf_empty), .full(rf_full)
    );
    assign fifo_valid_o = !rf_empty;

    always_ff @(posedge clk) begin
        if (rst || load_i)                        overflow_o <= 1'b0;
        else if (stage_vld && !flush_i && rf_full) overflow_o <= 1'b1;
    end
endmodule

// File: rtl/nsc_check.sv
module nsc_check #(
    parameter int CORES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             load_i,
    input logic             flush_i,
    input logic [CORES-1:0] core_req_i,
    input logic [CORES-1:0] core_gnt_o,
    input logic             done_o,
    input logic             overflow_o
);
    p_gnt_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(core_gnt_o));

    p_gnt_has_req_r4: assert property (@(posedge clk) disable iff (rst)
        (core_gnt_o & ~core_req_i) == '0);

    p_done_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (done_o && !load_i && !flush_i) |=> done_o);

    p_flush_no_gnt_r10: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (core_gnt_o == '0));

    p_flush_clears_done_r10: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> !done_o);

    p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (overflow_o && !load_i) |=> overflow_o);
endmodule

bind nonce_search_ctrl nsc_check #(.CORES(CORES)) u_nsc_check (
    .clk(clk), .rst(rst), .load_i(load_i), .flush_i(flush_i),
    .core_req_i(core_req_i), .core_gnt_o(core_gnt_o),
    .done_o(done_o), .overflow_o(overflow_o)
);

// File: tb/nonce_search_ctrl_test.sv
module nonce_search_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 32;
    localparam int HW = 256;
    localparam int WW = 96;
    localparam int NC = 4;
    localparam int RFD = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              load_i = 1'b0, flush_i = 1'b0;
    logic [WW-1:0]     work_i = '0;
    logic [NW-1:0]     first_i = '0, last_i = '0;
    logic [HW-1:0]     target_i = '0;
    logic [WW-1:0]     work_o;
    logic [NC-1:0]     core_req_i = '0, core_gnt_o;
    logic [NW-1:0]     cand_o;
    logic [NC-1:0]     res_valid_i = '0, res_ack_o;
    logic [NC*NW-1:0]  res_nonce_i = '0;
    logic [NC*HW-1:0]  res_hash_i = '0;
    logic              fifo_rd_i = 1'b0, fifo_valid_o;
    logic [NW-1:0]     fifo_nonce_o;
    logic              done_o, overflow_o;

    int checks = 0;
    int fails = 0;
    int last_gnt = NC - 1;
    bit finished = 1'b0;
    logic [HW-1:0] tgt;

    nonce_search_ctrl uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req,
                       input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic do_load(input logic [WW-1:0] w, input logic [NW-1:0] f,
                           input logic [NW-1:0] l, input logic [HW-1:0] t);
        @(negedge clk);
        load_i = 1'b1; work_i = w; first_i = f; last_i = l; target_i = t;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    function automatic int rr_expect(input logic [NC-1:0] req);
        for (int k = 1; k <= NC; k++)
            if (req[(last_gnt + k) % NC]) return (last_gnt + k) % NC;
        return -1;
    endfunction

    function automatic int gnt_index(input logic [NC-1:0] g);
        for (int i = 0; i < NC; i++) if (g[i]) return i;
        return -1;
    endfunction

    task automatic pop_expect(input logic [NW-1:0] exp, input string req);
        #1;
        chk(fifo_valid_o == 1'b1, req, fifo_valid_o, 1);
        chk(fifo_nonce_o == exp, req, fifo_nonce_o, exp);
        fifo_rd_i = 1'b1;
        @(negedge clk);
        fifo_rd_i = 1'b0;
    endtask

    task automatic set_res(input int c, input logic [NW-1:0] n, input logic [HW-1:0] h);
        res_valid_i[c] = 1'b1;
        res_nonce_i[c*NW +: NW] = n;
        res_hash_i[c*HW +: HW] = h;
    endtask

    task automatic t_reset();
        @(negedge clk);
        core_req_i = '1;
        #1;
        chk(core_gnt_o == '0, "R11 no grant", core_gnt_o, 0);
        chk(done_o == 1'b0, "R11 done", done_o, 0);
        chk(overflow_o == 1'b0, "R11 overflow", overflow_o, 0);
        chk(fifo_valid_o == 1'b0, "R11 fifo empty", fifo_valid_o, 0);
        core_req_i = '0;
    endtask

    task automatic t_sequence();
        int n = 0;
        do_load(96'hCAFE_0001_2345_6789_ABCD_EF01, 100, 105, '1);
        #1;
        chk(work_o == 96'hCAFE_0001_2345_6789_ABCD_EF01, "R1 work latched", work_o[63:0], 64'h2345_6789_ABCD_EF01);
        core_req_i = 4'b0001;
        for (int cyc = 0; cyc < 30; cyc++) begin
            @(negedge clk);
            #1;
            if (core_gnt_o[0]) begin
                chk(cand_o == NW'(100 + n), "R2 order", cand_o, 100 + n);
                n++;
                last_gnt = 0;
            end
        end
        core_req_i = '0;
        chk(n == 6, "R2 count once each", n, 6);
        chk(done_o == 1'b1, "R3 done after last", done_o, 1);
        do_load('0, 7, 8, '1);
        #1;
        chk(done_o == 1'b0, "R3 load clears done", done_o, 0);
        n = 0;
        core_req_i = 4'b0001;
        for (int cyc = 0; cyc < 10; cyc++) begin
            @(negedge clk);
            #1;
            if (core_gnt_o[0]) begin
                chk(cand_o == NW'(7 + n), "R3 restart", cand_o, 7 + n);
                n++;
            end
        end
        core_req_i = '0;
        chk(n == 2, "R3 restart count", n, 2);
    endtask

    task automatic t_roundrobin();
        int n = 0;
        do_load('0, 1000, 1011, '1);
        for (int cyc = 0; cyc < 40 && n < 12; cyc++) begin
            core_req_i = (n < 6) ? 4'b1111 : 4'b0101;
            #1;
            if (core_gnt_o != '0) begin
                chk($countones(core_gnt_o) == 1, "R4 one grant", core_gnt_o, 1);
                chk(gnt_index(core_gnt_o) == rr_expect(core_req_i), "R5 rotation",
                    gnt_index(core_gnt_o), rr_expect(core_req_i));
                chk(cand_o == NW'(1000 + n), "R2 unique in order", cand_o, 1000 + n);
                last_gnt = gnt_index(core_gnt_o);
                n++;
            end
            @(negedge clk);
        end
        core_req_i = '0;
        chk(n == 12, "R4 all issued", n, 12);
    endtask

    task automatic t_hits();
        tgt = {32'h0000_1000, 224'h0};
        do_load('0, 0, 0, tgt);
        @(negedge clk);
        set_res(0, 32'h11, tgt);
        set_res(3, 32'h33, tgt + 1);
        #1;
        chk(res_ack_o == 4'b1001, "R7 hit and miss acked", res_ack_o, 4'b1001);
        @(negedge clk);
        res_valid_i = '0;
        #1;
        chk(fifo_valid_o == 1'b0, "R6 not yet visible", fifo_valid_o, 0);
        @(negedge clk);
        pop_expect(32'h11, "R6 equal hash is hit");
        #1;
        chk(fifo_valid_o == 1'b0, "R6 miss not stored", fifo_valid_o, 0);
        set_res(1, 32'h21, '0);
        set_res(2, 32'h22, '0);
        #1;
        chk(res_ack_o == 4'b0010, "R7 first hit core1", res_ack_o, 4'b0010);
        @(negedge clk);
        res_valid_i[1] = 1'b0;
        #1;
        chk(res_ack_o == 4'b0100, "R7 second hit core2", res_ack_o, 4'b0100);
        @(negedge clk);
        res_valid_i = '0;
        @(negedge clk);
        pop_expect(32'h21, "R8 order first");
        pop_expect(32'h22, "R8 order second");
        #1;
        chk(fifo_valid_o == 1'b0, "R8 drained", fifo_valid_o, 0);
    endtask

    task automatic t_overflow();
        for (int i = 0; i <= RFD; i++) begin
            set_res(0, NW'(32'h50 + i), '0);
            #1;
            chk(res_ack_o[0] == 1'b1, "R7 hit acked", res_ack_o, 1);
            @(negedge clk);
        end
        res_valid_i = '0;
        @(negedge clk);
        #1;
        chk(overflow_o == 1'b1, "R9 overflow set", overflow_o, 1);
        for (int i = 0; i < RFD; i++) pop_expect(NW'(32'h50 + i), "R9 kept entries");
        #1;
        chk(fifo_valid_o == 1'b0, "R9 extra hit dropped", fifo_valid_o, 0);
        chk(overflow_o == 1'b1, "R9 sticky", overflow_o, 1);
        do_load('0, 0, 0, tgt);
        #1;
        chk(overflow_o == 1'b0, "R9 load clears", overflow_o, 0);
    endtask

    task automatic t_flush();
        do_load('0, 200, 299, tgt);
        set_res(0, 32'h66, '0);
        @(negedge clk);
        res_valid_i = '0;
        repeat (4) @(negedge clk);
        set_res(0, 32'h77, '0);
        @(negedge clk);
        res_valid_i = '0;
        flush_i = 1'b1;
        set_res(2, 32'h88, '0);
        #1;
        chk(res_ack_o[2] == 1'b1, "R10 ack during flush", res_ack_o, 4'b0100);
        @(negedge clk);
        flush_i = 1'b0;
        res_valid_i = '0;
        core_req_i = '1;
        for (int cyc = 0; cyc < 4; cyc++) begin
            #1;
            chk(core_gnt_o == '0, "R10 queue emptied", core_gnt_o, 0);
            chk(done_o == 1'b0, "R10 done low", done_o, 0);
            @(negedge clk);
        end
        core_req_i = '0;
        pop_expect(32'h66, "R10 fifo kept");
        #1;
        chk(fifo_valid_o == 1'b0, "R10 in-flight dropped", fifo_valid_o, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_sequence();
        t_roundrobin();
        t_hits();
        t_overflow();
        t_flush();
        repeat (2) @(negedge clk);
        summary();
    end
endmodule